// File: doc/BRIEF.md
# Deep-Sleep Wake Reset Sequencer

This block owns the reset line of a power-gated region of the chip. When the region is sent into deep sleep, the block asserts the region's reset. When a wakeup event arrives, the block first lets a voltage-settle counter run out at the full clock rate and waits for the power-good input. Only then does it run a prescaled countdown, and it releases the region's reset when that countdown is over.

Three values are held in a small read/write register port: a 5-bit prescaler exponent code, the reset count and the settle count. The prescaled tick divides the clock by a power of two given by the code. A status output shows when a wake sequence is in progress. A one-cycle pulse marks the moment reset is released. A new sleep entry during a wake sequence cancels that sequence at once.

Top module: `dsr_wake_seq`

## Requirements
- R1: After reset, the register at address 0 (prescaler code) reads 9, the register at address 1 (reset count) reads `RCNT_RST`, and the register at address 2 (settle count) reads `SETTLE_RST`. Each value sits in the low bits of `reg_rdata_o` with zeros above. A write stores the value, and a later read returns it.
- R2: For a prescaler code P from 1 to 31, the countdown decrements once every 2^(P-1) clock cycles. Code 9 gives 256.
- R3: Prescaler code 0 counts as divide by 1.
- R4: In the powered state with `dsleep_en_i` high, `sleep_i` sampled high at a clock edge makes `region_rst_o` high from that edge on.
- R5: With `dsleep_en_i` low, `sleep_i` has no effect, and `region_rst_o` stays low.
- R6: After a wakeup event, the countdown starts only when `pwr_good_i` is high and the settle counter has run out. The settle counter is loaded with S at the wake edge and decrements once per clock.
- R7: With settle count S, reset count N and divide ratio d, and with `pwr_good_i` high, `region_rst_o` falls S + N*d + 2 clock edges after the edge that samples `wake_i`.
- R8: `done_o` is high for exactly one cycle, in the first cycle that `region_rst_o` is low after a wake sequence.
- R9: `busy_o` is high only while the settle phase or the countdown is running. It is low in the powered state and in the sleep state.
- R10: `sleep_i` with `dsleep_en_i` high during the settle phase or the countdown cancels the sequence. `region_rst_o` stays high, `busy_o` drops at the next edge, and reset is never released until a new wakeup event arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data (combinational) |
| dsleep_en_i | input | 1 | Deep-sleep enable control |
| sleep_i | input | 1 | Deep-sleep entry request |
| wake_i | input | 1 | Wakeup event |
| pwr_good_i | input | 1 | Power-good indication for the gated region |
| region_rst_o | output | 1 | Reset to the gated region |
| busy_o | output | 1 | Wake sequence in progress |
| done_o | output | 1 | One-cycle pulse at reset release |

## Verification
The bench uses the default parameters: 8-bit reset and settle counts, reset values 16 and 4, and a 5-bit prescaler code. With these values the default divide by 256 can be measured exactly within a short run. The bench stays on small counts and low codes (0 to 5), so every release edge can be predicted exactly from S + N*d + 2. This covers the divide-by-1 handling of code 0, a delayed power-good, and cancellation in the middle of a countdown.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
  typedef enum logic [1:0] {
    ST_ON     = 2'd0,
    ST_SLEEP  = 2'd1,
    ST_SETTLE = 2'd2,
    ST_COUNT  = 2'd3
  } seq_state_e;

  localparam logic [1:0] ADDR_PRE    = 2'd0;
  localparam logic [1:0] ADDR_RCNT   = 2'd1;
  localparam logic [1:0] ADDR_SETTLE = 2'd2;
endpackage

// File: rtl/dsr_regs.sv
module dsr_regs
  import dsr_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int PRE_W      = 5,
  parameter int CNT_W      = 8,
  parameter int SETTLE_W   = 8,
  parameter int PRE_RST    = 9,
  parameter int RCNT_RST   = 16,
  parameter int SETTLE_RST = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [1:0]          addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic [PRE_W-1:0]    pre_code_o,
  output logic [CNT_W-1:0]    rcnt_o,
  output logic [SETTLE_W-1:0] settle_o
);
  logic [PRE_W-1:0]    pre_q;
  logic [CNT_W-1:0]    rcnt_q;
  logic [SETTLE_W-1:0] settle_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q    <= PRE_W'(PRE_RST);
      rcnt_q   <= CNT_W'(RCNT_RST);
      settle_q <= SETTLE_W'(SETTLE_RST);
    end else if (we_i) begin
      case (addr_i)
        ADDR_PRE:    pre_q    <= wdata_i[PRE_W-1:0];
        ADDR_RCNT:   rcnt_q   <= wdata_i[CNT_W-1:0];
        ADDR_SETTLE: settle_q <= wdata_i[SETTLE_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_PRE:    rdata_o = DATA_W'(pre_q);
      ADDR_RCNT:   rdata_o = DATA_W'(rcnt_q);
      ADDR_SETTLE: rdata_o = DATA_W'(settle_q);
      default:     rdata_o = '0;
    endcase
  end

  assign pre_code_o = pre_q;
  assign rcnt_o     = rcnt_q;
  assign settle_o   = settle_q;
endmodule

// File: rtl/dsr_prescaler.sv
module dsr_prescaler #(
  parameter int PRE_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [PRE_W-1:0] code_i,
  output logic             tick_o
);
  localparam int DIV_W = (1 << PRE_W) - 1;

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim;
  logic [PRE_W-1:0] code_eff;

  // reserved code 0 behaves as divide by 1
  assign code_eff = (code_i == '0) ? PRE_W'(1) : code_i;
  assign lim      = (DIV_W'(1) << (code_eff - PRE_W'(1))) - DIV_W'(1);
  assign tick_o   = run_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                      cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/dsr_settle_cnt.sv
module dsr_settle_cnt #(
  parameter int SETTLE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [SETTLE_W-1:0] load_val_i,
  output logic                expired_o
);
  logic [SETTLE_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= load_val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - SETTLE_W'(1);
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/dsr_fsm.sv
module dsr_fsm
  import dsr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dsleep_en_i,
  input  logic             sleep_i,
  input  logic             wake_i,
  input  logic             pwr_good_i,
  input  logic             settle_done_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] rcnt_i,
  output seq_state_e       state_o,
  output logic             settle_load_o,
  output logic             region_rst_o,
  output logic             busy_o,
  output logic             done_o
);
  seq_state_e       state_q;
  logic [CNT_W-1:0] dec_q;
  logic             done_q;
  logic             enter;

  assign enter = sleep_i && dsleep_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_ON;
      dec_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_ON:     if (enter) state_q <= ST_SLEEP;
        ST_SLEEP:  if (wake_i) state_q <= ST_SETTLE;
        ST_SETTLE: begin
          if (enter) state_q <= ST_SLEEP;
          else if (settle_done_i && pwr_good_i) begin
            state_q <= ST_COUNT;
            dec_q   <= rcnt_i;
          end
        end
        ST_COUNT: begin
          if (enter) state_q <= ST_SLEEP;
          else if (dec_q == '0) begin
            state_q <= ST_ON;
            done_q  <= 1'b1;
          end else if (tick_i) dec_q <= dec_q - CNT_W'(1);
        end
        default: state_q <= ST_SLEEP;
      endcase
    end
  end

  assign state_o       = state_q;
  assign settle_load_o = (state_q == ST_SLEEP) && wake_i;
  assign region_rst_o  = (state_q != ST_ON);
  assign busy_o        = (state_q == ST_SETTLE) || (state_q == ST_COUNT);
  assign done_o        = done_q;
endmodule

// File: rtl/dsr_wake_seq.sv
module dsr_wake_seq
  import dsr_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int PRE_W      = 5,
  parameter int CNT_W      = 8,
  parameter int SETTLE_W   = 8,
  parameter int PRE_RST    = 9,
  parameter int RCNT_RST   = 16,
  parameter int SETTLE_RST = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              dsleep_en_i,
  input  logic              sleep_i,
  input  logic              wake_i,
  input  logic              pwr_good_i,
  output logic              region_rst_o,
  output logic              busy_o,
  output logic              done_o
);
  logic [PRE_W-1:0]    pre_code;
  logic [CNT_W-1:0]    rcnt;
  logic [SETTLE_W-1:0] settle_val;
  logic                settle_load;
  logic                settle_done;
  logic                tick;
  seq_state_e          state_q;

  dsr_regs #(
    .DATA_W(DATA_W), .PRE_W(PRE_W), .CNT_W(CNT_W), .SETTLE_W(SETTLE_W),
    .PRE_RST(PRE_RST), .RCNT_RST(RCNT_RST), .SETTLE_RST(SETTLE_RST)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .pre_code_o(pre_code), .rcnt_o(rcnt), .settle_o(settle_val)
  );

  dsr_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(state_q == ST_COUNT),
    .code_i(pre_code), .tick_o(tick)
  );

  dsr_settle_cnt #(.SETTLE_W(SETTLE_W)) u_settle (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(settle_load),
    .load_val_i(settle_val), .expired_o(settle_done)
  );

  dsr_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .dsleep_en_i(dsleep_en_i),
    .sleep_i(sleep_i), .wake_i(wake_i), .pwr_good_i(pwr_good_i),
    .settle_done_i(settle_done), .tick_i(tick), .rcnt_i(rcnt),
    .state_o(state_q), .settle_load_o(settle_load),
    .region_rst_o(region_rst_o), .busy_o(busy_o), .done_o(done_o)
  );
endmodule

// File: rtl/dsr_wake_seq_chk.sv
module dsr_wake_seq_chk
  import dsr_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       dsleep_en_i,
  input logic       sleep_i,
  input logic       pwr_good_i,
  input logic       region_rst_o,
  input logic       busy_o,
  input logic       done_o,
  input logic [1:0] state_q
);
  p_sleep_entry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!region_rst_o && sleep_i && dsleep_en_i) |=> region_rst_o);

  p_disabled_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!region_rst_o && !dsleep_en_i) |=> !region_rst_o);

  p_pg_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SETTLE && !pwr_good_i) |=> (state_q != ST_COUNT));

  p_done_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!region_rst_o && $past(busy_o)));

  p_busy_in_reset_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> region_rst_o);

  p_abort_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && sleep_i && dsleep_en_i) |=> (region_rst_o && !busy_o && !done_o));
endmodule

bind dsr_wake_seq dsr_wake_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .dsleep_en_i(dsleep_en_i),
  .sleep_i(sleep_i), .pwr_good_i(pwr_good_i), .region_rst_o(region_rst_o),
  .busy_o(busy_o), .done_o(done_o), .state_q(state_q)
);

// File: tb/dsr_wake_seq_test.sv
module dsr_wake_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        dsleep_en = 1'b1;
  logic        sleep = 1'b0;
  logic        wake = 1'b0;
  logic        pwr_good = 1'b1;
  logic        region_rst, busy, done;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  dsr_wake_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .dsleep_en_i(dsleep_en),
    .sleep_i(sleep), .wake_i(wake), .pwr_good_i(pwr_good),
    .region_rst_o(region_rst), .busy_o(busy), .done_o(done)
  );

  // prescaler code, reset count, settle count, expected release edge count
  localparam int VEC [7][4] = '{
    '{1, 5, 3, 10},
    '{2, 4, 0, 10},
    '{3, 3, 2, 16},
    '{0, 6, 1, 9},
    '{4, 2, 5, 23},
    '{1, 0, 0, 2},
    '{5, 1, 1, 19}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input int v);
    @(negedge clk);
    reg_addr = a; reg_wdata = 32'(v); reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input int exp, input string req);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(reg_rdata == 32'(exp), req, int'(reg_rdata), exp);
  endtask

  task automatic go_sleep();
    @(negedge clk); sleep = 1'b1;
    @(negedge clk); sleep = 1'b0;
    chk(region_rst == 1'b1, "R4 reset after entry", int'(region_rst), 1);
  endtask

  // wake and return edges until release
  task automatic wake_measure(output int n);
    n = 0;
    @(negedge clk); wake = 1'b1;
    @(posedge clk);
    @(negedge clk); wake = 1'b0;
    while (region_rst && n < 4000) begin
      @(posedge clk); n++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(region_rst == 1'b0, "R9 reset state rst", int'(region_rst), 0);
    chk(busy == 1'b0 && done == 1'b0, "R9 reset state busy/done", int'(busy), 0);
    rd_chk(2'd0, 9, "R1 prescaler reset");
    rd_chk(2'd1, 16, "R1 count reset");
    rd_chk(2'd2, 4, "R1 settle reset");

    // R2 default divide 256: N=1, S=0 -> 258
    wr(2'd1, 1); wr(2'd2, 0);
    go_sleep();
    wake_measure(n);
    chk(n == 258, "R2 default divide 256", n, 258);

    for (int i = 0; i < 7; i++) begin
      wr(2'd0, VEC[i][0]); wr(2'd1, VEC[i][1]); wr(2'd2, VEC[i][2]);
      rd_chk(2'd0, VEC[i][0], "R1 readback");
      go_sleep();
      @(negedge clk);
      chk(busy == 1'b0, "R9 idle in sleep", int'(busy), 0);
      wake_measure(n);
      chk(n == VEC[i][3], (VEC[i][0] == 0) ? "R3 code zero timing" : "R7 release timing",
          n, VEC[i][3]);
      chk(done == 1'b1, "R8 done at release", int'(done), 1);
      @(negedge clk);
      chk(done == 1'b0, "R8 done single cycle", int'(done), 0);
      chk(busy == 1'b0, "R9 busy low when powered", int'(busy), 0);
    end

    // R6 delayed power-good: S=2,N=3,code1, pg at edge 10 -> 15
    wr(2'd0, 1); wr(2'd1, 3); wr(2'd2, 2);
    go_sleep();
    pwr_good = 1'b0;
    @(negedge clk); wake = 1'b1;
    @(posedge clk);
    @(negedge clk); wake = 1'b0;
    chk(busy == 1'b1, "R9 busy in settle", int'(busy), 1);
    n = 0;
    for (int k = 0; k < 10; k++) begin
      @(posedge clk); n++;
      @(negedge clk);
    end
    chk(region_rst == 1'b1, "R6 held without power-good", int'(region_rst), 1);
    pwr_good = 1'b1;
    while (region_rst && n < 4000) begin
      @(posedge clk); n++;
      @(negedge clk);
    end
    chk(n == 15, "R6 release after power-good", n, 15);

    // R10 abort mid countdown
    wr(2'd1, 20); wr(2'd2, 0);
    go_sleep();
    @(negedge clk); wake = 1'b1;
    @(negedge clk); wake = 1'b0;
    repeat (5) @(negedge clk);
    sleep = 1'b1;
    @(negedge clk); sleep = 1'b0;
    chk(region_rst == 1'b1 && busy == 1'b0, "R10 abort", int'(busy), 0);
    repeat (30) @(negedge clk);
    chk(region_rst == 1'b1, "R10 no release after abort", int'(region_rst), 1);
    wake_measure(n);
    chk(n == 22, "R10 fresh sequence after abort", n, 22);

    // R5 disabled entry ignored
    dsleep_en = 1'b0;
    @(negedge clk); sleep = 1'b1;
    @(negedge clk); sleep = 1'b0;
    chk(region_rst == 1'b0, "R5 sleep ignored when disabled", int'(region_rst), 0);
    @(negedge clk); wake = 1'b1;
    @(negedge clk); wake = 1'b0;
    @(negedge clk);
    chk(region_rst == 1'b0 && busy == 1'b0, "R5 still powered", int'(busy), 0);
    dsleep_en = 1'b1;

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule